// File: doc/BRIEF.md
# Write-Through Store Path with Optional Store Buffer

This block handles processor stores for a data cache in two kinds of regions. Stores to write-through regions always go out on the external bus. When they hit, they also refresh the cached word. Stores to cache-inhibited regions go out on the bus and never touch the cache array. A store that misses never causes a line fill. This is a no-allocate policy, so the block has no fill request at all.

A single-entry store buffer sits in front of the bus. A control input enables it. With the buffer enabled, a write-through store or an imprecise cache-inhibited store finishes for the processor as soon as it is latched into the empty buffer. Precise cache-inhibited stores, and all stores when the buffer is off, take the direct path. On that path the processor is held until the bus acknowledges the write. Bus writes leave in the order the stores were accepted. A direct store therefore waits behind an occupied buffer entry.

A pulse on the invalidate-all input is forwarded to the array. In that same cycle it takes priority over any word update.

Top module: `wt_store_path`

## Requirements
- R1: After reset the buffer is empty and `bus_req`, `arr_wr_en` and `arr_inval_all` are low while no store or invalidate is presented.
- R2: Every accepted store produces exactly one bus write that carries its address, data and byte enables. While `bus_req` is high and `bus_ack` is low, the bus request and its fields stay unchanged.
- R3: With `buf_en` high and the buffer empty, a store of mode 2'b00 (write-through) or 2'b10 (inhibited, imprecise) is accepted in the cycle it is presented. `bus_req` rises in the next cycle, carrying the buffered fields.
- R4: While the buffer holds an entry, `st_ready` stays low for any new store, including in the cycle the entry's acknowledge arrives.
- R5: With `buf_en` low, a store is accepted only in a cycle where `bus_ack` is high. Until then `bus_req` presents the store's own fields directly.
- R6: A store of mode 2'b01 (inhibited, precise) or 2'b11 (treated as precise) bypasses the buffer even when `buf_en` is high, and it waits for `bus_ack`.
- R7: A write-through store that hits (`arr_hit` high) raises `arr_wr_en` in its acceptance cycle. The array write carries the store's address, data and byte enables.
- R8: A write-through store that misses produces no array write.
- R9: A cache-inhibited store never writes the array and never invalidates, whether it hits or misses.
- R10: `inval_all` drives `arr_inval_all` in the same cycle and suppresses `arr_wr_en` in that cycle.
- R11: A direct store presented while the buffer holds an entry does not reach the bus until the buffered write has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_en | input | 1 | Store buffer enable |
| inval_all | input | 1 | Invalidate whole data cache, pulse |
| st_valid | input | 1 | Processor store request |
| st_mode | input | 2 | 00 write-through, 01 inhibited precise, 10 inhibited imprecise, 11 as precise |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| st_ready | output | 1 | Store accepted/completed this cycle |
| arr_addr | output | ADDR_W | Array lookup and update address |
| arr_hit | input | 1 | Lookup hit a valid line |
| arr_wr_en | output | 1 | Update cached word |
| arr_wr_data | output | DATA_W | Update data |
| arr_wr_be | output | DATA_W/8 | Update byte enables |
| arr_inval_all | output | 1 | Invalidate all lines |
| bus_req | output | 1 | External write request |
| bus_addr | output | ADDR_W | Write address |
| bus_data | output | DATA_W | Write data |
| bus_be | output | DATA_W/8 | Write byte enables |
| bus_ack | input | 1 | Write acknowledge |

## Verification
The bench builds the block with an 8-bit address and 16-bit data, which gives two byte-enable lanes. This keeps every field value small enough to compute from the loop indices. It sweeps all four mode codes against both buffer settings, hit and miss, and acknowledge latencies of zero to two cycles. That covers every pairing of path choice and cache effect. Dedicated sequences then fill the buffer and present a second buffered store, place a precise store behind a buffered entry, and raise the invalidate during a hitting store.

// File: rtl/wt_pkg.sv
package wt_pkg;
    typedef enum logic [1:0] {
        MODE_WT       = 2'b00,
        MODE_CI_PREC  = 2'b01,
        MODE_CI_IMPR  = 2'b10,
        MODE_CI_RSVD  = 2'b11
    } st_mode_e;
endpackage

// File: rtl/wt_store_decode.sv
module wt_store_decode
    import wt_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       buf_en,
    output logic       cacheable,
    output logic       buffered
);
    st_mode_e m;
    always_comb begin
        m         = st_mode_e'(mode);
        cacheable = (m == MODE_WT);
        // precise and reserved codes never use the buffer
        buffered  = buf_en && ((m == MODE_WT) || (m == MODE_CI_IMPR));
    end
endmodule

// File: rtl/wt_store_buf.sv
module wt_store_buf #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  logic                  pop,
    input  logic [ADDR_W-1:0]     in_addr,
    input  logic [DATA_W-1:0]     in_data,
    input  logic [DATA_W/8-1:0]   in_be,
    output logic                  vld,
    output logic [ADDR_W-1:0]     addr,
    output logic [DATA_W-1:0]     data,
    output logic [DATA_W/8-1:0]   be
);
    localparam int BE_W = DATA_W / 8;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } ent_t;

    ent_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (pop) begin
            ent_d.vld = 1'b0;
        end
        if (push) begin
            ent_d.vld  = 1'b1;
            ent_d.addr = in_addr;
            ent_d.data = in_data;
            ent_d.be   = in_be;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign vld  = ent_q.vld;
    assign addr = ent_q.addr;
    assign data = ent_q.data;
    assign be   = ent_q.be;
endmodule

// File: rtl/wt_bus_mux.sv
module wt_bus_mux #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                  buf_vld,
    input  logic [ADDR_W-1:0]     buf_addr,
    input  logic [DATA_W-1:0]     buf_data,
    input  logic [DATA_W/8-1:0]   buf_be,
    input  logic                  direct_go,
    input  logic [ADDR_W-1:0]     st_addr,
    input  logic [DATA_W-1:0]     st_data,
    input  logic [DATA_W/8-1:0]   st_be,
    output logic                  bus_req,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [DATA_W-1:0]     bus_data,
    output logic [DATA_W/8-1:0]   bus_be
);
    always_comb begin
        // an occupied buffer entry always goes first
        bus_req = buf_vld || direct_go;
        if (buf_vld) begin
            bus_addr = buf_addr;
            bus_data = buf_data;
            bus_be   = buf_be;
        end else begin
            bus_addr = st_addr;
            bus_data = st_data;
            bus_be   = st_be;
        end
    end
endmodule

// File: rtl/wt_store_path.sv
module wt_store_path #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  buf_en,
    input  logic                  inval_all,
    input  logic                  st_valid,
    input  logic [1:0]            st_mode,
    input  logic [ADDR_W-1:0]     st_addr,
    input  logic [DATA_W-1:0]     st_data,
    input  logic [DATA_W/8-1:0]   st_be,
    output logic                  st_ready,
    output logic [ADDR_W-1:0]     arr_addr,
    input  logic                  arr_hit,
    output logic                  arr_wr_en,
    output logic [DATA_W-1:0]     arr_wr_data,
    output logic [DATA_W/8-1:0]   arr_wr_be,
    output logic                  arr_inval_all,
    output logic                  bus_req,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [DATA_W-1:0]     bus_data,
    output logic [DATA_W/8-1:0]   bus_be,
    input  logic                  bus_ack
);
    localparam int BE_W = DATA_W / 8;

    logic              cacheable, buffered;
    logic              buf_vld, buf_push, buf_pop, direct_go, accept;
    logic [ADDR_W-1:0] buf_addr;
    logic [DATA_W-1:0] buf_data;
    logic [BE_W-1:0]   buf_be;

    wt_store_decode u_dec (
        .mode      (st_mode),
        .buf_en    (buf_en),
        .cacheable (cacheable),
        .buffered  (buffered)
    );

    always_comb begin
        buf_push  = st_valid && buffered && !buf_vld;
        buf_pop   = buf_vld && bus_ack;
        direct_go = st_valid && !buffered && !buf_vld;
        st_ready  = buffered ? !buf_vld : (!buf_vld && bus_ack);
        accept    = st_valid && st_ready;
    end

    wt_store_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (buf_push),
        .pop     (buf_pop),
        .in_addr (st_addr),
        .in_data (st_data),
        .in_be   (st_be),
        .vld     (buf_vld),
        .addr    (buf_addr),
        .data    (buf_data),
        .be      (buf_be)
    );

    wt_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .buf_vld   (buf_vld),
        .buf_addr  (buf_addr),
        .buf_data  (buf_data),
        .buf_be    (buf_be),
        .direct_go (direct_go),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .st_be     (st_be),
        .bus_req   (bus_req),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .bus_be    (bus_be)
    );

    // word update on hit; no allocation on miss; inhibited never touches
    always_comb begin
        arr_addr      = st_addr;
        arr_wr_data   = st_data;
        arr_wr_be     = st_be;
        arr_inval_all = inval_all;
        arr_wr_en     = accept && cacheable && arr_hit && !inval_all;
    end
endmodule

// File: rtl/wt_store_path_chk.sv
module wt_store_path_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              buf_en,
    input logic              st_valid,
    input logic [1:0]        st_mode,
    input logic              st_ready,
    input logic              arr_hit,
    input logic              arr_wr_en,
    input logic              arr_inval_all,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack
);
    // R3
    buf_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && buf_en && !st_mode[0]) |=> bus_req);
    // R5
    direct_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && !buf_en) |-> bus_ack);
    // R6
    precise_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && st_mode[0]) |-> bus_ack);
    // R7
    wr_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> (st_valid && st_ready && arr_hit && st_mode == 2'b00));
    // R10
    inval_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_inval_all |-> !arr_wr_en);
    // R2
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));
endmodule

bind wt_store_path wt_store_path_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .buf_en        (buf_en),
    .st_valid      (st_valid),
    .st_mode       (st_mode),
    .st_ready      (st_ready),
    .arr_hit       (arr_hit),
    .arr_wr_en     (arr_wr_en),
    .arr_inval_all (arr_inval_all),
    .bus_req       (bus_req),
    .bus_addr      (bus_addr),
    .bus_ack       (bus_ack)
);

// File: tb/wt_store_path_test.sv
module wt_store_path_test;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int BW = DW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic buf_en = 1'b0, inval_all = 1'b0, st_valid = 1'b0, arr_hit = 1'b0, bus_ack = 1'b0;
    logic [1:0] st_mode = 2'b00;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [BW-1:0] st_be = '0;
    logic st_ready, arr_wr_en, arr_inval_all, bus_req;
    logic [AW-1:0] arr_addr, bus_addr;
    logic [DW-1:0] arr_wr_data, bus_data;
    logic [BW-1:0] arr_wr_be, bus_be;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    wt_store_path #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .inval_all(inval_all),
        .st_valid(st_valid), .st_mode(st_mode), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .st_ready(st_ready),
        .arr_addr(arr_addr), .arr_hit(arr_hit), .arr_wr_en(arr_wr_en),
        .arr_wr_data(arr_wr_data), .arr_wr_be(arr_wr_be),
        .arr_inval_all(arr_inval_all), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_be(bus_be), .bus_ack(bus_ack)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic chk_bus(input string req, input int a, input int d, input int b);
        chk(req, "bus_req", int'(bus_req), 1);
        chk(req, "bus_addr", int'(bus_addr), a);
        chk(req, "bus_data", int'(bus_data), d);
        chk(req, "bus_be", int'(bus_be), b);
    endtask

    // one store, waits for its bus write; entered and left at a negedge
    task automatic do_store(input int mode, input int ben, input int hit, input int lat,
                            input int a, input int d, input int b);
        bit buffered = (ben != 0) && (mode == 0 || mode == 2);
        bit upd = (mode == 0) && (hit != 0);
        buf_en = ben[0]; st_mode = mode[1:0]; arr_hit = hit[0];
        st_addr = a[AW-1:0]; st_data = d[DW-1:0]; st_be = b[BW-1:0];
        st_valid = 1'b1;
        if (buffered) begin
            bus_ack = 1'b0;
            #1;
            chk("R3", "st_ready buffered", int'(st_ready), 1);
            chk(upd ? "R7" : (mode == 0 ? "R8" : "R9"), "arr_wr_en", int'(arr_wr_en), int'(upd));
            chk("R3", "bus_req before fill", int'(bus_req), 0);
            if (upd) chk("R7", "arr_wr_data", int'(arr_wr_data), d);
            @(negedge clk);
            st_valid = 1'b0;
            for (int i = 0; i <= lat; i++) begin
                bus_ack = (i == lat);
                #1;
                chk_bus("R3", a, d, b);
                @(negedge clk);
            end
        end else begin
            for (int i = 0; i <= lat; i++) begin
                bus_ack = (i == lat);
                #1;
                chk_bus(mode[0] ? "R6" : "R5", a, d, b);
                chk(mode[0] ? "R6" : "R5", "st_ready direct", int'(st_ready), int'(i == lat));
                chk(upd ? "R7" : (mode == 0 ? "R8" : "R9"), "arr_wr_en",
                    int'(arr_wr_en), int'(upd && i == lat));
                chk("R9", "arr_inval_all", int'(arr_inval_all), 0);
                @(negedge clk);
            end
            st_valid = 1'b0;
        end
        bus_ack = 1'b0;
        #1;
        chk("R2", "single bus write", int'(bus_req), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1
        chk("R1", "bus_req reset", int'(bus_req), 0);
        chk("R1", "arr_wr_en reset", int'(arr_wr_en), 0);
        chk("R1", "arr_inval_all reset", int'(arr_inval_all), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "bus_req after reset", int'(bus_req), 0);

        // sweep: mode x buffer enable x hit x ack latency
        for (int m = 0; m < 4; m++)
            for (int e = 0; e < 2; e++)
                for (int h = 0; h < 2; h++)
                    for (int l = 0; l < 3; l++)
                        do_store(m, e, h, l, (m * 24 + e * 12 + h * 3 + l + 1) & 8'hff,
                                 16'h1000 + m * 256 + e * 16 + h * 4 + l,
                                 (m + l) % 3 + 1);
        @(negedge clk);

        // R4: second buffered store while the entry is occupied
        buf_en = 1'b1; st_mode = 2'b00; arr_hit = 1'b0; st_valid = 1'b1;
        st_addr = 8'h A1; st_data = 16'h AAAA; st_be = 2'b11;
        #1; chk("R4", "first accepted", int'(st_ready), 1);
        @(negedge clk);
        st_addr = 8'h B2; st_data = 16'h BBBB; st_be = 2'b01;
        #1; chk("R4", "stall when full", int'(st_ready), 0);
        chk_bus("R4", 8'hA1, 16'hAAAA, 2'b11);
        @(negedge clk);
        bus_ack = 1'b1;
        #1; chk("R4", "stall during ack", int'(st_ready), 0);
        @(negedge clk);
        bus_ack = 1'b0;
        #1; chk("R4", "accept after drain", int'(st_ready), 1);
        chk("R4", "bus idle after drain", int'(bus_req), 0);
        @(negedge clk);
        st_valid = 1'b0; bus_ack = 1'b1;
        #1; chk_bus("R4", 8'hB2, 16'hBBBB, 2'b01);
        @(negedge clk);
        bus_ack = 1'b0;

        // R11: precise store behind a buffered entry
        st_mode = 2'b00; st_valid = 1'b1; st_addr = 8'h C3; st_data = 16'h CCCC; st_be = 2'b10;
        #1; chk("R11", "buffered accepted", int'(st_ready), 1);
        @(negedge clk);
        st_mode = 2'b01; st_addr = 8'h D4; st_data = 16'h DDDD; st_be = 2'b11; bus_ack = 1'b1;
        #1; chk_bus("R11", 8'hC3, 16'hCCCC, 2'b10);
        chk("R11", "direct held", int'(st_ready), 0);
        @(negedge clk);
        bus_ack = 1'b0;
        #1; chk_bus("R11", 8'hD4, 16'hDDDD, 2'b11);
        chk("R11", "direct waits ack", int'(st_ready), 0);
        bus_ack = 1'b1;
        #1; chk("R11", "direct done", int'(st_ready), 1);
        @(negedge clk);
        st_valid = 1'b0; bus_ack = 1'b0;
        #1; chk("R11", "bus idle", int'(bus_req), 0);

        // R10: invalidate alongside a hitting write-through store
        @(negedge clk);
        inval_all = 1'b1; st_mode = 2'b00; arr_hit = 1'b1; st_valid = 1'b1;
        st_addr = 8'h E5; st_data = 16'h EEEE; st_be = 2'b11;
        #1; chk("R10", "arr_inval_all", int'(arr_inval_all), 1);
        chk("R10", "update suppressed", int'(arr_wr_en), 0);
        chk("R10", "store accepted", int'(st_ready), 1);
        @(negedge clk);
        inval_all = 1'b0; st_valid = 1'b0; bus_ack = 1'b1;
        #1; chk_bus("R10", 8'hE5, 16'hEEEE, 2'b11);
        chk("R10", "inval released", int'(arr_inval_all), 0);
        @(negedge clk);
        bus_ack = 1'b0;
        #1; chk("R2", "bus idle at end", int'(bus_req), 0);

        finish_run();
    end
endmodule